// File: doc/BRIEF.md
# Multiplexed-Bus Register Slave

This block lets a host processor reach a small register file over a shared 8-bit address/data bus. In the address phase the host raises an address latch enable. The block then captures the low five bus lines on a falling clock edge. A transfer starts when the active-low strobe is seen at a rising edge, provided both chip selects are valid. The block then stores or returns one byte. It answers every accepted transfer with a single-cycle active-low ready pulse.

The two byte-enable inputs act as the two lowest address bits. With the five latched bits they form a 7-bit register index, so the file holds 128 bytes. One index is a read-only status byte that shows the pending interrupt. The user-logic interrupt request is passed straight to an active-low interrupt output. It stays there for as long as user logic holds it.

The bidirectional bus is split into an input, an output and an output enable. A pad wrapper above the block combines them into the shared bus.

Top module: `mux_bus_slave`

## Requirements
- R1: The address is taken from `bus_in[4:0]` only on a falling clock edge with `ale` high. The register index is {latched address, `be[1:0]`}, with `be` as the least-significant bits, and `be` is sampled at the strobe edge.
- R2: A strobe is accepted only when `cs_lo_n` is 0 and `cs_hi` is 1 at the strobe edge. Any other strobe gives no ready pulse and changes no register.
- R3: On a write (`wr_rd` = 1 at the strobe edge), the byte on `bus_in` at the rising edge one cycle after the strobe edge is stored at the selected index. A later read of that index returns it.
- R4: Every accepted transfer drives `rdy_n` low for exactly one clock cycle. That cycle runs from the rising edge one cycle after the strobe edge to the following rising edge.
- R5: On a read (`wr_rd` = 0), `bus_oe` is 1 and `bus_out` holds the addressed byte during the ready cycle only. At all other times, and on every write, `bus_oe` is 0.
- R6: Index 0 is the status register. Bit 0 reads the current interrupt request and bits 7:1 read 0. Writes to it are ignored.
- R7: `irq_n` equals the inverse of `usr_irq` at all times. It is independent of bus activity and stays low for as long as the request is held.
- R8: After reset, `rdy_n` is 1, `bus_oe` is 0 and every register reads 0.
- R9: A strobe seen while a transfer is still in progress (before or during its ready cycle) is ignored. It gives no second ready pulse and makes no write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address latch enable, sampled on the falling edge |
| ads_n | input | 1 | Active-low address/data strobe |
| wr_rd | input | 1 | Direction: 1 write, 0 read |
| be | input | 2 | Byte enables, used as index bits 1:0 |
| cs_lo_n | input | 1 | Active-low chip select |
| cs_hi | input | 1 | Active-high chip select |
| bus_in | input | 8 | Shared bus, input side |
| bus_out | output | 8 | Shared bus, output side |
| bus_oe | output | 1 | Bus output enable |
| rdy_n | output | 1 | Active-low one-cycle ready/acknowledge |
| usr_irq | input | 1 | Interrupt request from user logic |
| irq_n | output | 1 | Active-low interrupt to the host |

## Verification
The checker watches four things on every cycle. The ready pulse never lasts more than one cycle. Every fall of ready traces back to a selected strobe two edges earlier. The output enable is only ever on inside a ready cycle, and only after a read strobe. Whether the stored bytes are right can only be shown by the bench scenarios. The same goes for the falling-edge address capture, the status-byte contents and the effect of ignored strobes. The bench sweeps every index with writes and read-backs, tries each invalid chip-select pair, and holds the strobe across a busy transfer.

// File: rtl/mux_bus_slave.sv
module mux_bus_slave #(
  parameter int DW       = 8,
  parameter int AW       = 5,
  parameter int BEW      = 2,
  parameter int STAT_IDX = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ale,
  input  logic           ads_n,
  input  logic           wr_rd,
  input  logic [BEW-1:0] be,
  input  logic           cs_lo_n,
  input  logic           cs_hi,
  input  logic [DW-1:0]  bus_in,
  output logic [DW-1:0]  bus_out,
  output logic           bus_oe,
  output logic           rdy_n,
  input  logic           usr_irq,
  output logic           irq_n
);
  localparam int IW   = AW + BEW;
  localparam int NREG = 1 << IW;

  logic [AW-1:0] addr_q;
  logic [IW-1:0] idx_q;
  logic          busy_q, ack_q, wr_q;
  logic [DW-1:0] rd_q;
  logic [DW-1:0] regs [NREG];
  logic [DW-1:0] status;

  wire selected = !cs_lo_n && cs_hi;
  wire start    = !ads_n && selected && !busy_q && !ack_q;
  wire is_stat  = (idx_q == IW'(STAT_IDX));

  assign status = {{(DW-1){1'b0}}, usr_irq};

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n)   addr_q <= '0;
    else if (ale) addr_q <= bus_in[AW-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy_q <= 1'b0;
      ack_q  <= 1'b0;
      wr_q   <= 1'b0;
      idx_q  <= '0;
      rd_q   <= '0;
    end else begin
      ack_q <= busy_q;
      if (start) begin
        busy_q <= 1'b1;
        idx_q  <= {addr_q, be};
        wr_q   <= wr_rd;
      end else if (busy_q) begin
        busy_q <= 1'b0;
        rd_q   <= is_stat ? status : regs[idx_q];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (busy_q && wr_q && !is_stat) begin
      regs[idx_q] <= bus_in;
    end

  assign bus_oe  = ack_q && !wr_q;
  assign bus_out = bus_oe ? rd_q : '0;
  assign rdy_n   = !ack_q;
  assign irq_n   = !usr_irq;
endmodule

// File: rtl/mux_bus_slave_chk.sv
module mux_bus_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic ads_n,
  input logic wr_rd,
  input logic cs_lo_n,
  input logic cs_hi,
  input logic bus_oe,
  input logic rdy_n
);
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_n |=> rdy_n); // R4
  AST_ACK_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_n) |-> $past(!ads_n && !cs_lo_n && cs_hi, 2)); // R2
  AST_OE_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !rdy_n); // R5
  AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> $past(!wr_rd, 2)); // R5
endmodule

bind mux_bus_slave mux_bus_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .wr_rd(wr_rd),
  .cs_lo_n(cs_lo_n), .cs_hi(cs_hi), .bus_oe(bus_oe), .rdy_n(rdy_n)
);

// File: tb/mux_bus_slave_tb.sv
module mux_bus_slave_tb;
  logic       clk = 0, rst_n = 0, ale = 0, ads_n = 1, wr_rd = 0;
  logic [1:0] be = 0;
  logic       cs_lo_n = 1, cs_hi = 0, usr_irq = 0;
  logic [7:0] bus_in = 0;
  logic [7:0] bus_out;
  logic       bus_oe, rdy_n, irq_n;
  int checks = 0, errors = 0;
  logic [7:0] model [128];

  always #5 clk = ~clk;

  mux_bus_slave u_dut (
    .clk(clk), .rst_n(rst_n), .ale(ale), .ads_n(ads_n), .wr_rd(wr_rd), .be(be),
    .cs_lo_n(cs_lo_n), .cs_hi(cs_hi), .bus_in(bus_in), .bus_out(bus_out),
    .bus_oe(bus_oe), .rdy_n(rdy_n), .usr_irq(usr_irq), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit w, input logic [6:0] idx, input logic [7:0] d,
                      input bit sn, input bit s, input bit hold,
                      output logic [3:0] ackv, output logic [3:0] oev, output logic [7:0] rd);
    @(posedge clk); #1 ale = 1; bus_in = {3'b0, idx[6:2]};
    @(negedge clk); #1 ale = 0;
    @(posedge clk); #1 ads_n = 0; wr_rd = w; be = idx[1:0]; cs_lo_n = sn; cs_hi = s;
    @(posedge clk); #1 bus_in = w ? d : 8'hA5;
    if (hold) be = idx[1:0] ^ 2'b01; else ads_n = 1;
    @(negedge clk); ackv[0] = rdy_n; oev[0] = bus_oe;
    @(posedge clk); #1 ads_n = 1;
    @(negedge clk); ackv[1] = rdy_n; oev[1] = bus_oe; rd = bus_out;
    @(negedge clk); ackv[2] = rdy_n; oev[2] = bus_oe;
    @(negedge clk); ackv[3] = rdy_n; oev[3] = bus_oe;
    cs_lo_n = 1; cs_hi = 0;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] a, o;
    logic [7:0] r;
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R8 rdy_n reset", rdy_n, 1);
    chk("R8 bus_oe reset", bus_oe, 0);
    chk("R7 irq_n idle", irq_n, 1);
    xfer(0, 7'd77, 8'h00, 0, 1, 0, a, o, r);
    chk("R8 register zero after reset", r, 8'h00);

    for (int i = 1; i < 128; i++) begin
      logic [7:0] d = 8'((i * 37 + 11) & 255);
      xfer(1, 7'(i), d, 0, 1, 0, a, o, r);
      model[i] = d;
      chk("R4 write ready pattern", a, 4'b1101);
      chk("R5 no drive on write", o, 4'b0000);
    end
    for (int i = 1; i < 128; i++) begin
      xfer(0, 7'(i), 8'h00, 0, 1, 0, a, o, r);
      chk("R3 R1 read-back", r, model[i]);
      chk("R4 read ready pattern", a, 4'b1101);
      chk("R5 drive only in ready cycle", o, 4'b0010);
    end

    xfer(1, 7'd0, 8'hFF, 0, 1, 0, a, o, r);
    chk("R6 status write acked", a, 4'b1101);
    xfer(0, 7'd0, 8'h00, 0, 1, 0, a, o, r);
    chk("R6 status idle", r, 8'h00);
    #1 usr_irq = 1;
    #2 chk("R7 irq_n asserted", irq_n, 0);
    xfer(0, 7'd0, 8'h00, 0, 1, 0, a, o, r);
    chk("R6 status pending", r, 8'h01);
    repeat (20) @(posedge clk);
    #1 chk("R7 irq_n held", irq_n, 0);
    usr_irq = 0;
    #2 chk("R7 irq_n released", irq_n, 1);
    xfer(0, 7'd0, 8'h00, 0, 1, 0, a, o, r);
    chk("R6 status cleared", r, 8'h00);

    for (int c = 0; c < 3; c++) begin
      bit sn = (c != 1);
      bit s  = (c == 1) ? 1'b0 : (c == 0);
      xfer(1, 7'd5, 8'h3C, sn, s, 0, a, o, r);
      chk("R2 no ready when deselected", a, 4'b1111);
      chk("R2 no drive when deselected", o, 4'b0000);
      xfer(0, 7'd5, 8'h00, 0, 1, 0, a, o, r);
      chk("R2 register untouched", r, model[5]);
    end

    xfer(1, 7'd9, 8'h77, 0, 1, 1, a, o, r);
    model[9] = 8'h77;
    chk("R9 single ready under held strobe", a, 4'b1101);
    xfer(0, 7'd9, 8'h00, 0, 1, 0, a, o, r);
    chk("R9 first write stored", r, 8'h77);
    xfer(0, 7'd8, 8'h00, 0, 1, 0, a, o, r);
    chk("R9 second strobe made no write", r, model[8]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule